// File: doc/BRIEF.md
# Sub-block reset control register

This block is a memory-mapped register that decides which of five on-chip sub-blocks are running and which are held in reset. Each register bit has "running" polarity: a one lets the matching sub-block run, and a zero holds it in reset. The block drives one active-low reset output per sub-block, and each output comes straight from its state flop.

Software reaches the register through four consecutive word addresses. The first address loads every bit directly. The second releases only the bits written as one. The third places in reset only the bits written as one. A write to the fourth address does nothing. A read from any of the four addresses returns the current state one cycle after the read strobe.

A parameter decides whether the fifth (auxiliary) bit exists. When it does not, that bit reads zero, ignores writes and keeps its reset output low.

Top module: `blkResetReg`

## Requirements
- R1: After the block's own reset, every state bit is zero, every reset output `blkRstN` is low and `busRdData` is zero.
- R2: A write to word address BASE_ADDR+0 (direct) loads every implemented bit from `busWrData[4:0]`. A one releases the sub-block and a zero puts it into reset.
- R3: A write to BASE_ADDR+1 (set) releases each sub-block whose data bit is one and leaves the other sub-blocks unchanged.
- R4: A write to BASE_ADDR+2 (clear) puts into reset each sub-block whose data bit is one and leaves the other sub-blocks unchanged.
- R5: A write to BASE_ADDR+3, or to any address outside the four-word window, leaves the state and the reset outputs unchanged.
- R6: A read strobe to any of the four aliases returns the current state on `busRdData[4:0]` in the next cycle, with bits 31 to 5 zero. A read strobe outside the window returns zero. Without a read strobe, `busRdData` holds its value.
- R7: When a read and a write are strobed in the same cycle, the read returns the state from before the write, and the write still takes effect.
- R8: `blkRstN[i]` follows state bit i and changes in the cycle after the write. The bit order is: 0 misc core, 1 global register controller, 2 first ring bus controller, 3 second ring bus controller, 4 auxiliary ring bus.
- R9: With HAS_AUX=0, bit 4 always reads zero, ignores writes on every alias and keeps `blkRstN[4]` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of this block |
| busAddr | input | ADDR_W | Word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, valid the cycle after the read strobe |
| blkRstN | output | NUM_BLK | Active-low reset, one per sub-block |

## Verification
A read and a write can fall in the same cycle, and that cycle decides whether the read returns the state from before or after the update. The bench strobes both together on the direct, set and clear aliases. It expects read data equal to the state before the write, and expects reset outputs in the next cycle that show the write applied. A behavioural reference model is compared every cycle against both a five-bit instance and a four-bit instance.

// File: rtl/blkRstPkg.sv
package blkRstPkg;
  typedef struct packed {
    logic wrDirect;
    logic wrSet;
    logic wrClear;
    logic rdHit;
    logic rdMiss;
  } regStrobes_t;
endpackage

// File: rtl/blkRstDecode.sv
module blkRstDecode
  import blkRstPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h08050
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrobes_t       strobes
);
  logic       inWindow;
  logic [1:0] aliasSel;

  assign inWindow = (busAddr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
  assign aliasSel = busAddr[1:0];

  always_comb begin
    strobes          = '0;
    strobes.wrDirect = busWrEn && inWindow && (aliasSel == 2'd0);
    strobes.wrSet    = busWrEn && inWindow && (aliasSel == 2'd1);
    strobes.wrClear  = busWrEn && inWindow && (aliasSel == 2'd2);
    strobes.rdHit    = busRdEn && inWindow;
    strobes.rdMiss   = busRdEn && !inWindow;
  end

  // R5: at most one write alias fires, and none fires without a write strobe
  a_r5_one_write_alias: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrDirect, strobes.wrSet, strobes.wrClear}) &&
    (busWrEn || !(strobes.wrDirect || strobes.wrSet || strobes.wrClear)));
endmodule

// File: rtl/blkRstState.sv
module blkRstState
  import blkRstPkg::*;
#(
  parameter int NUM_BLK = 5,
  parameter int DATA_W  = 32,
  parameter bit HAS_AUX = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strobes,
  input  logic [DATA_W-1:0]  wrData,
  output logic [NUM_BLK-1:0] stateQ,
  output logic [DATA_W-1:0]  rdDataQ
);
  localparam int AUX_IDX = NUM_BLK - 1;
  localparam logic [NUM_BLK-1:0] IMPL_MASK =
    HAS_AUX ? {NUM_BLK{1'b1}} : {1'b0, {(NUM_BLK-1){1'b1}}};

  logic [NUM_BLK-1:0] wrBits;
  assign wrBits = wrData[NUM_BLK-1:0];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_bit
    if (i != AUX_IDX || HAS_AUX) begin : g_impl
      logic nextBit;
      always_comb begin
        nextBit = stateQ[i];
        if (strobes.wrDirect)     nextBit = wrBits[i];
        else if (strobes.wrSet)   nextBit = stateQ[i] | wrBits[i];
        else if (strobes.wrClear) nextBit = stateQ[i] & ~wrBits[i];
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stateQ[i] <= 1'b0;
        else       stateQ[i] <= nextBit;
      end
    end else begin : g_absent
      assign stateQ[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdDataQ <= '0;
    else if (strobes.rdHit)  rdDataQ <= {{(DATA_W-NUM_BLK){1'b0}}, stateQ};
    else if (strobes.rdMiss) rdDataQ <= '0;
  end

  // R2: direct alias loads the implemented bits
  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDirect |=> stateQ == ($past(wrBits) & IMPL_MASK));
  // R3: set alias releases the bits written as one
  a_r3_set_releases: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrSet |=> (stateQ & $past(wrBits & IMPL_MASK)) == $past(wrBits & IMPL_MASK));
  // R4: clear alias puts into reset the bits written as one
  a_r4_clear_resets: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrClear |=> (stateQ & $past(wrBits)) == '0);
  // R5: no write alias means no state change
  a_r5_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrDirect || strobes.wrSet || strobes.wrClear) |=> $stable(stateQ));
  // R6 R7: read returns the state from before any same-cycle write
  a_r7_read_before_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdHit |=> rdDataQ == {{(DATA_W-NUM_BLK){1'b0}}, $past(stateQ)});
endmodule

// File: rtl/blkResetReg.sv
module blkResetReg
  import blkRstPkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 32,
  parameter int NUM_BLK = 5,
  parameter bit HAS_AUX = 1'b1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h08050
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  output logic [NUM_BLK-1:0] blkRstN
);
  regStrobes_t        strobes;
  logic [NUM_BLK-1:0] stateQ;

  blkRstDecode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strobes(strobes));

  blkRstState #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W), .HAS_AUX(HAS_AUX)) u_state (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .stateQ(stateQ), .rdDataQ(busRdData));

  // R8: each running bit drives its active-low reset high, straight from the flop
  assign blkRstN = stateQ;
endmodule

// File: tb/test_blkResetReg.sv
module test_blkResetReg;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int NB = 5;
  localparam logic [AW-1:0] BASE = 20'h08050;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] rdA, rdB;
  logic [NB-1:0] rstA, rstB;

  int checks = 0, errors = 0;
  int expStA = 0, expStB = 0, expRdA = 0, expRdB = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blkResetReg #(.HAS_AUX(1'b1)) i_blkResetReg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdA), .blkRstN(rstA));
  blkResetReg #(.HAS_AUX(1'b0)) i_blkResetRegNoAux (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdB), .blkRstN(rstB));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int modelWrite(int st, int al, int d, int mask);
    int n = st;
    case (al)
      0: n = d;
      1: n = st | d;
      2: n = st & ~d;
      default: n = st;
    endcase
    return n & mask;
  endfunction

  task automatic step(string tag, int addr, bit we, int wd, bit re);
    bit hit;
    @(negedge clk);
    busAddr = addr[AW-1:0]; busWrEn = we; busWrData = wd; busRdEn = re;
    @(posedge clk); #1;
    hit = (addr[AW-1:2] == int'(BASE[AW-1:2]));
    if (re) begin
      expRdA = hit ? expStA : 0;
      expRdB = hit ? expStB : 0;
    end
    if (we && hit) begin
      expStA = modelWrite(expStA, addr & 3, wd, 'h1F);
      expStB = modelWrite(expStB, addr & 3, wd, 'h0F);
    end
    check({tag, " outputs"}, int'(rstA), expStA);
    check({tag, " outputs noaux"}, int'(rstB), expStB);
    check({tag, " rdata"}, int'(rdA), expRdA);
    check({tag, " rdata noaux"}, int'(rdB), expRdB);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", int'(rstA), 0);
    check("R1 reset rdata", int'(rdA), 0);
    rstN = 1'b1;
    step("R1 idle", 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step("R6 read alias", int'(BASE) + k, 0, 0, 1);
    step("R2 direct 15", int'(BASE), 1, 'h15, 0);
    step("R8 bit order misc core", int'(BASE), 1, 'h01, 0);
    step("R2 direct all ones", int'(BASE), 1, 'hFFFF_FFFF, 0);
    for (int k = 0; k < 4; k++) step("R6 read upper zero", int'(BASE) + k, 0, 0, 1);
    step("R4 clear 03", int'(BASE) + 2, 1, 'h03, 0);
    step("R4 clear zeros", int'(BASE) + 2, 1, 'h00, 1);
    step("R3 set 02", int'(BASE) + 1, 1, 'h02, 0);
    step("R3 set zeros", int'(BASE) + 1, 1, 'h00, 1);
    step("R5 alias3 write", int'(BASE) + 3, 1, 'h00, 0);
    step("R5 alias3 write ones", int'(BASE) + 3, 1, 'hFFFF_FFFF, 1);
    step("R5 outside window", int'(BASE) + 4, 1, 'h00, 0);
    step("R5 below window", int'(BASE) - 1, 1, 'h00, 0);
    step("R6 read miss", int'(BASE) + 7, 0, 0, 1);
    step("R6 hold", int'(BASE), 0, 0, 0);
    step("R7 read with direct", int'(BASE), 1, 'h0A, 1);
    step("R7 read with set", int'(BASE) + 1, 1, 'h11, 1);
    step("R7 read with clear", int'(BASE) + 2, 1, 'h1C, 1);
    step("R9 aux set", int'(BASE) + 1, 1, 'h10, 1);
    step("R9 aux read", int'(BASE) + 2, 0, 0, 1);
    step("R9 aux clear", int'(BASE) + 2, 1, 'h10, 1);
    for (int k = 0; k < 5; k++) begin
      step("R8 walk direct", int'(BASE), 1, 1 << k, 0);
      step("R8 walk read", int'(BASE) + k % 4, 0, 0, 1);
    end
    step("R1 end idle", 0, 0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule